// File: doc/BRIEF.md
# Clock-Loop Holdover Mode Controller

This block is the mode state machine of a digitally controlled clock loop. It watches a validity flag for each reference input, the index of the input that the selector has picked, and the loop's lock indicator. From these it keeps the loop in one of four modes: free-run, locked, holdover or exiting. It also drives the strobes that the neighbouring logic needs. The frequency-history recorder gets a write enable and a freeze strobe. The holdover frequency register gets a load strobe. A ramp generator gets a start pulse and returns a done flag. A bandwidth-select line tells the loop filter which bandwidth governs a non-ramped exit.

Holdover is a last resort. When the selected input fails and some other input is still valid, the controller asks the selector to switch inputs and stays locked. Holdover is entered only when no input is valid at all. On entry the loop is told to load the averaged history value. When the selected input becomes valid again, the controller moves to the exiting mode. It leaves that mode through a linear ramp or through a bandwidth-limited pull-in. The choice is captured at the moment of exit, and the ramped path is the reset default.

Top module: `clkloop_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode becomes free-run (code 0) and `hold_load` and `ramp_start` become 0. The mode codes are free-run 0, locked 1, holdover 2 and exiting 3.
- R2: In free-run, a clock edge with the selected input valid and `lock_ind` high moves the mode to locked. Without both conditions the mode stays free-run.
- R3: `hist_wr_en` is high only while the mode is locked and the selected input is valid. It is low in every other mode.
- R4: While the mode is locked, `hist_freeze` is high in the same cycle that the selected input's flag is low. It is low in every other mode.
- R5: If the selected input is invalid in locked mode and another input is valid, `switch_req` is high in that same cycle and the mode stays locked.
- R6: If the selected input is invalid in locked mode and no other input is valid, the mode becomes holdover at the next edge. `hold_load` is high for exactly one cycle, which is the first cycle in holdover.
- R7: In holdover, a clock edge with the selected input valid moves the mode to exiting. At that edge the exit path is latched from `cfg_ramp_exit` (1 means ramped) and the bandwidth choice is latched from `cfg_exit_bw_sel`.
- R8: On a ramped exit, `ramp_start` is high for exactly one cycle, which is the first cycle in exiting. The mode then stays exiting until an edge with `ramp_done` high, and `lock_ind` has no effect during this wait. After that edge the mode is locked.
- R9: On a non-ramped exit, `ramp_start` stays low. The mode stays exiting until an edge with `lock_ind` high and then becomes locked. While in exiting, `bw_hold_sel` equals the latched `cfg_exit_bw_sel` (1 selects the holdover-exit bandwidth), and later changes to `cfg_exit_bw_sel` have no effect. Outside this state `bw_hold_sel` is 0.
- R10: If the selected input becomes invalid during exiting, the mode returns to holdover at the next edge and `hold_load` stays low.
- R11: In holdover, while the selected input is invalid and another input is valid, `switch_req` is high and the mode stays holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_IN | Validity flag, one per reference input |
| sel_idx | input | SEL_W | Index of the input picked by the selector |
| lock_ind | input | 1 | Loop lock indicator |
| cfg_ramp_exit | input | 1 | 1: ramped holdover exit, 0: bandwidth-limited exit |
| cfg_exit_bw_sel | input | 1 | Non-ramped exit: 1 holdover-exit bandwidth, 0 normal loop bandwidth |
| ramp_done | input | 1 | Ramp generator has reached the target frequency |
| mode | output | 2 | Current mode code |
| hist_wr_en | output | 1 | Frequency-history write enable |
| hist_freeze | output | 1 | Freeze strobe for the history recorder |
| hold_load | output | 1 | Load averaged history into the holdover frequency |
| ramp_start | output | 1 | Start pulse to the ramp generator |
| switch_req | output | 1 | Request to the selector to switch to another valid input |
| bw_hold_sel | output | 1 | Loop filter uses the holdover-exit bandwidth |

## Verification
The failure of the selected input is tested with two validity patterns. In the first, another input is still valid. In the second, no input is valid. Together they separate an input switch from holdover entry, both in locked mode and in holdover. The exit is run in both configurations. In the ramped run, `lock_ind` is raised early, which shows that only `ramp_done` ends the wait. In the non-ramped run, the bandwidth bit is changed after the exit begins, which shows that it was latched. A second failure during the exiting mode confirms that the mode returns to holdover without a second load strobe.

// File: rtl/clkloop_pkg.sv
// Shared types for the clock-loop mode controller.
package clkloop_pkg;
    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_LOCKED = 2'd1,
        MODE_HOLD   = 2'd2,
        MODE_EXIT   = 2'd3
    } loop_mode_e;
endpackage

// File: rtl/clkloop_input_scan.sv
// Input scan: reduces the per-input validity flags to two facts. The first
// is whether the selected input is valid. The second is whether any other
// input is valid. Assumes that sel_idx addresses an existing input.
module clkloop_input_scan #(
    parameter int N_IN  = 4,
    parameter int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0]  in_valid,
    input  logic [SEL_W-1:0] sel_idx,
    output logic             sel_valid,
    output logic             other_valid
);
    logic [N_IN-1:0] sel_hit;
    logic [N_IN-1:0] other_hit;

    // Split each input's flag into the selected position and the others.
    for (genvar g = 0; g < N_IN; g++) begin : g_scan
        assign sel_hit[g]   = in_valid[g] && (sel_idx == SEL_W'(g));
        assign other_hit[g] = in_valid[g] && (sel_idx != SEL_W'(g));
    end

    // Reduce the split vectors to single flags.
    assign sel_valid   = |sel_hit;
    assign other_valid = |other_hit;
endmodule

// File: rtl/clkloop_mode_fsm.sv
// Mode state machine: free-run, locked, holdover and exiting. It also
// latches the exit path and the exit bandwidth when holdover is left.
// Assumes synchronous inputs. The ramp generator raises ramp_done only
// after it has been started.
module clkloop_mode_fsm
    import clkloop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_valid,
    input  logic       other_valid,
    input  logic       lock_ind,
    input  logic       cfg_ramp_exit,
    input  logic       cfg_exit_bw_sel,
    input  logic       ramp_done,
    output loop_mode_e mode_q,
    output logic       exit_ramped_q,
    output logic       exit_bw_q,
    output logic       enter_hold,
    output logic       enter_ramp
);
    loop_mode_e mode_d;

    // Next-mode decision.
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FREE:   if (sel_valid && lock_ind) mode_d = MODE_LOCKED;
            MODE_LOCKED: if (!sel_valid && !other_valid) mode_d = MODE_HOLD;
            MODE_HOLD:   if (sel_valid) mode_d = MODE_EXIT;
            MODE_EXIT: begin
                if (!sel_valid)
                    mode_d = MODE_HOLD;
                else if (exit_ramped_q ? ramp_done : lock_ind)
                    mode_d = MODE_LOCKED;
            end
            default:     mode_d = MODE_FREE;
        endcase
    end

    // Transition flags for the strobe stage.
    assign enter_hold = (mode_q == MODE_LOCKED) && (mode_d == MODE_HOLD);
    assign enter_ramp = (mode_q == MODE_HOLD) && (mode_d == MODE_EXIT) && cfg_ramp_exit;

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_FREE;
        else        mode_q <= mode_d;
    end

    // Capture the exit configuration at the moment holdover is left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exit_ramped_q <= 1'b1;
            exit_bw_q     <= 1'b0;
        end else if (mode_q == MODE_HOLD && mode_d == MODE_EXIT) begin
            exit_ramped_q <= cfg_ramp_exit;
            exit_bw_q     <= cfg_exit_bw_sel;
        end
    end

    AST_RESET_FREE: assert property (@(posedge clk) !rst_n |=> mode_q == MODE_FREE); // R1
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOCKED && !sel_valid && !other_valid) |=> mode_q == MODE_HOLD); // R6
    AST_SWITCH_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LOCKED && !sel_valid && other_valid) |=> mode_q == MODE_LOCKED); // R5
    AST_HOLD_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && sel_valid) |=> mode_q == MODE_EXIT); // R7
    AST_RAMP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EXIT && exit_ramped_q && sel_valid && !ramp_done) |=> mode_q == MODE_EXIT); // R8
    AST_EXIT_REFAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_EXIT && !sel_valid) |=> mode_q == MODE_HOLD); // R10
endmodule

// File: rtl/clkloop_strobes.sv
// Strobe stage: turns the mode-transition flags into registered one-cycle
// pulses. The pulses appear in the first cycle of the new mode. Assumes
// that a flag is never high in two consecutive cycles.
module clkloop_strobes (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_hold,
    input  logic enter_ramp,
    output logic hold_load,
    output logic ramp_start
);
    // Register the transition flags into pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_load  <= 1'b0;
            ramp_start <= 1'b0;
        end else begin
            hold_load  <= enter_hold;
            ramp_start <= enter_ramp;
        end
    end

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_load |=> !hold_load); // R6
    AST_RAMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_start |=> !ramp_start); // R8
endmodule

// File: rtl/clkloop_mode_ctrl.sv
// Top of the holdover mode controller. It joins the input scan, the mode
// state machine and the strobe stage, and derives the combinational
// outputs for the history recorder, the selector and the loop filter.
// Assumes that all inputs are synchronous to clk.
module clkloop_mode_ctrl
    import clkloop_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [SEL_W-1:0] sel_idx,
    input  logic             lock_ind,
    input  logic             cfg_ramp_exit,
    input  logic             cfg_exit_bw_sel,
    input  logic             ramp_done,
    output logic [1:0]       mode,
    output logic             hist_wr_en,
    output logic             hist_freeze,
    output logic             hold_load,
    output logic             ramp_start,
    output logic             switch_req,
    output logic             bw_hold_sel
);
    logic       sel_valid;
    logic       other_valid;
    loop_mode_e mode_q;
    logic       exit_ramped_q;
    logic       exit_bw_q;
    logic       enter_hold;
    logic       enter_ramp;

    clkloop_input_scan #(.N_IN(N_IN), .SEL_W(SEL_W)) u_scan (
        .in_valid    (in_valid),
        .sel_idx     (sel_idx),
        .sel_valid   (sel_valid),
        .other_valid (other_valid)
    );

    clkloop_mode_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_valid       (sel_valid),
        .other_valid     (other_valid),
        .lock_ind        (lock_ind),
        .cfg_ramp_exit   (cfg_ramp_exit),
        .cfg_exit_bw_sel (cfg_exit_bw_sel),
        .ramp_done       (ramp_done),
        .mode_q          (mode_q),
        .exit_ramped_q   (exit_ramped_q),
        .exit_bw_q       (exit_bw_q),
        .enter_hold      (enter_hold),
        .enter_ramp      (enter_ramp)
    );

    clkloop_strobes u_strobes (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_hold (enter_hold),
        .enter_ramp (enter_ramp),
        .hold_load  (hold_load),
        .ramp_start (ramp_start)
    );

    // Combinational outputs to the neighbouring logic.
    always_comb begin
        mode        = mode_q;
        hist_wr_en  = (mode_q == MODE_LOCKED) && sel_valid;
        hist_freeze = (mode_q == MODE_LOCKED) && !sel_valid;
        switch_req  = ((mode_q == MODE_LOCKED) || (mode_q == MODE_HOLD)) && !sel_valid && other_valid;
        bw_hold_sel = (mode_q == MODE_EXIT) && !exit_ramped_q && exit_bw_q;
    end

    AST_FREEZE_STOPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_freeze && !switch_req) |=> !hist_wr_en); // R4
    AST_WRITE_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        hist_wr_en |-> mode == 2'd1); // R3
endmodule

// File: tb/clkloop_mode_ctrl_test.sv
module clkloop_mode_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [N_IN-1:0] in_valid;
    logic [1:0] sel_idx;
    logic       lock_ind, cfg_ramp_exit, cfg_exit_bw_sel, ramp_done;
    logic [1:0] mode;
    logic       hist_wr_en, hist_freeze, hold_load, ramp_start, switch_req, bw_hold_sel;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] M_FREE = 2'd0, M_LOCK = 2'd1, M_HOLD = 2'd2, M_EXIT = 2'd3;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkloop_mode_ctrl #(.N_IN(N_IN)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_idx(sel_idx),
        .lock_ind(lock_ind), .cfg_ramp_exit(cfg_ramp_exit),
        .cfg_exit_bw_sel(cfg_exit_bw_sel), .ramp_done(ramp_done),
        .mode(mode), .hist_wr_en(hist_wr_en), .hist_freeze(hist_freeze),
        .hold_load(hold_load), .ramp_start(ramp_start),
        .switch_req(switch_req), .bw_hold_sel(bw_hold_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = '0; sel_idx = 2'd0; lock_ind = 1'b0;
        cfg_ramp_exit = 1'b1; cfg_exit_bw_sel = 1'b0; ramp_done = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        settle();
    endtask

    task automatic go_locked();
        do_reset();
        in_valid = 4'b0001; lock_ind = 1'b1;
        tick();
    endtask

    task automatic go_hold();
        go_locked();
        in_valid = 4'b0000;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode after reset", mode, M_FREE);
        chk("R1 hold_load after reset", hold_load, 0);
        chk("R1 ramp_start after reset", ramp_start, 0);
    endtask

    task automatic t_lock();
        do_reset();
        in_valid = 4'b0001; lock_ind = 1'b0;
        settle();
        chk("R3 no history write in free-run", hist_wr_en, 0);
        tick();
        chk("R2 stays free-run without lock", mode, M_FREE);
        lock_ind = 1'b1;
        tick();
        chk("R2 locked after lock", mode, M_LOCK);
        chk("R3 history write while locked", hist_wr_en, 1);
        chk("R4 no freeze while valid", hist_freeze, 0);
    endtask

    task automatic t_switch();
        go_locked();
        in_valid = 4'b0100;
        settle();
        chk("R5 switch_req same cycle", switch_req, 1);
        chk("R4 freeze same cycle", hist_freeze, 1);
        chk("R3 no history write after failure", hist_wr_en, 0);
        tick();
        chk("R5 mode stays locked", mode, M_LOCK);
        chk("R5 hold_load low", hold_load, 0);
    endtask

    task automatic t_hold_entry();
        go_locked();
        in_valid = 4'b0000;
        settle();
        chk("R4 freeze on failure", hist_freeze, 1);
        chk("R5 no switch without other input", switch_req, 0);
        tick();
        chk("R6 holdover entered", mode, M_HOLD);
        chk("R6 hold_load first cycle", hold_load, 1);
        chk("R4 no freeze in holdover", hist_freeze, 0);
        tick();
        chk("R6 hold_load one cycle", hold_load, 0);
        chk("R6 stays holdover", mode, M_HOLD);
    endtask

    task automatic t_ramp_exit();
        go_hold();
        cfg_ramp_exit = 1'b1; lock_ind = 1'b0; in_valid = 4'b0001;
        tick();
        chk("R7 exiting after input returns", mode, M_EXIT);
        chk("R8 ramp_start first cycle", ramp_start, 1);
        chk("R9 normal bandwidth on ramped exit", bw_hold_sel, 0);
        lock_ind = 1'b1;
        tick();
        chk("R8 ramp_start one cycle", ramp_start, 0);
        chk("R8 lock ignored while ramping", mode, M_EXIT);
        ramp_done = 1'b1;
        tick();
        chk("R8 locked after ramp_done", mode, M_LOCK);
        ramp_done = 1'b0;
    endtask

    task automatic t_bw_exit();
        go_hold();
        cfg_ramp_exit = 1'b0; cfg_exit_bw_sel = 1'b1; lock_ind = 1'b0;
        in_valid = 4'b0001;
        tick();
        chk("R7 exiting on non-ramped path", mode, M_EXIT);
        chk("R9 no ramp_start", ramp_start, 0);
        chk("R9 holdover-exit bandwidth", bw_hold_sel, 1);
        cfg_exit_bw_sel = 1'b0; ramp_done = 1'b1;
        tick();
        chk("R9 bandwidth latched", bw_hold_sel, 1);
        chk("R9 ramp_done ignored", mode, M_EXIT);
        ramp_done = 1'b0; lock_ind = 1'b1;
        tick();
        chk("R9 locked after lock", mode, M_LOCK);
        chk("R9 bandwidth select cleared", bw_hold_sel, 0);
    endtask

    task automatic t_refail();
        go_hold();
        cfg_ramp_exit = 1'b0; lock_ind = 1'b0; in_valid = 4'b0001;
        tick();
        chk("R10 exiting before refail", mode, M_EXIT);
        in_valid = 4'b0000;
        tick();
        chk("R10 back to holdover", mode, M_HOLD);
        chk("R10 no hold_load", hold_load, 0);
    endtask

    task automatic t_hold_switch();
        go_hold();
        in_valid = 4'b0010;
        settle();
        chk("R11 switch_req in holdover", switch_req, 1);
        tick();
        chk("R11 stays holdover", mode, M_HOLD);
        sel_idx = 2'd1;
        tick();
        chk("R7 exit on newly selected input", mode, M_EXIT);
    endtask

    initial begin
        t_reset();
        t_lock();
        t_switch();
        t_hold_entry();
        t_ramp_exit();
        t_bw_exit();
        t_refail();
        t_hold_switch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule